// File: doc/BRIEF.md
# Paired-Page PQ Coalescing State Front End

This block is the memory-mapped front end for a table of queue descriptors. Each descriptor carries two 2-bit coalescing states, one for notification and one for escalation. Software reaches them through a window of two pages per descriptor. The even page of the pair acts on the notification state and the odd page on the escalation state. Within a page, the low twelve address bits pick the operation: trigger, end-of-interrupt (EOI), read, or a forced set.

Every accepted access runs a fixed two-cycle read-modify-write on the selected state. The descriptor table lives in an internal register array. A small configuration port marks descriptors valid or invalid. When an operation decides that an event must be forwarded, the block pulses a notify strobe. Accesses to invalid descriptors, accesses of the wrong size and unsupported store offsets leave all state untouched. Such loads return all-ones.

Top module: `pq_page_mmio`

## Requirements
- R1: The descriptor index is `req_addr >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` selects the notification state (0) or the escalation state (1). The operation offset is `req_addr[11:0]`. A state is encoded as bit 1 = P and bit 0 = Q. Load data carries the result in its low bits, zero-extended to 64 bits.
- R2: A store at offset 0x000–0x3FF is a trigger. The transitions are 00→10 with notify, and 01→11, 10→11 and 11→11 without notify.
- R3: A load at 0x000–0x7FF and a store at 0x400–0x7FF are EOI operations. The transitions are 11→10 with notify, and 00, 01 and 10 all going to 00 without notify. An EOI load returns 1 when it notifies and 0 otherwise.
- R4: A load at 0x800–0xBFF returns the current state and changes nothing.
- R5: A load at 0xC00–0xFFF sets the state to offset bits [9:8] and returns the previous state.
- R6: A store at 0x800–0xFFF has no effect and gives no notify.
- R7: For a descriptor that is invalid, or whose index is at or beyond NUM_DESC, a load returns all-ones and a store changes nothing and gives no notify.
- R8: An access whose `req_size` is not 8 is treated like R7.
- R9: An access is accepted on a clock edge while `req_ready` is high, and `req_ready` is low for the following cycle. For loads, `rsp_valid` is high for exactly the cycle after that. Stores never raise `rsp_valid`.
- R10: `notify_o` is a one-cycle pulse, aligned with the response slot, raised only by a trigger or EOI that notifies.
- R11: A stored state changes only when an operation writes a different value. Writing the valid flag through the configuration port leaves both states of that descriptor as they were.
- R12: After reset all states are 00, all descriptors are invalid, `req_ready` is 1, and `rsp_valid` and `notify_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when an access can be accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Load result |
| notify_o | output | 1 | Event forwarding strobe |
| cfg_we | input | 1 | Write descriptor valid flag |
| cfg_idx | input | IDX_W | Descriptor to configure |
| cfg_valid | input | 1 | New valid flag |

## Verification
The bench targets the page-parity split. It moves one state of a descriptor and reads the other back. A decoder that ignored bit `PAGE_SHIFT` would show the first state's value where 0 is expected. It drives every trigger and EOI transition, including the 01 cases, which an implementation that only checked P would get wrong. It also checks the 11→10 EOI, which must both notify and return 1.

The bench mixes the rejected cases (store offsets above 0x7FF, short accesses, invalid descriptors) with reads that follow them. A design that let any of these through would either change the read value or raise a stray notify. Finally, the bench toggles the valid flag of a descriptor that holds state and checks that the state survives. A design that cleared the state on configuration would read 00.

// File: rtl/pqm_pkg.sv
package pqm_pkg;

  typedef enum logic [2:0] {
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_BAD
  } pq_op_e;

  localparam logic [63:0] ALL_ONES = '1;

  // returns {notify, next_state}
  function automatic logic [2:0] pq_trigger(input logic [1:0] cur);
    case (cur)
      2'b00:   return {1'b1, 2'b10};
      default: return {1'b0, 2'b11};
    endcase
  endfunction

  // returns {notify, next_state}
  function automatic logic [2:0] pq_eoi(input logic [1:0] cur);
    if (cur == 2'b11) return {1'b1, 2'b10};
    return {1'b0, 2'b00};
  endfunction

  function automatic pq_op_e pq_decode(input logic is_store, input logic [11:0] off);
    if (is_store) begin
      if (off < 12'h400) return OP_TRIG;
      if (off < 12'h800) return OP_EOI;
      return OP_BAD;
    end
    if (off < 12'h800) return OP_EOI;
    if (off < 12'hC00) return OP_GET;
    return OP_SET;
  endfunction

  function automatic logic [1:0] pq_set_value(input logic [11:0] off);
    return off[9:8];
  endfunction

endpackage

// File: rtl/pqm_addr_decode.sv
module pqm_addr_decode
  import pqm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 4,
  parameter int IDX_W      = 2
) (
  input  logic              is_store,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              odd_page,
  output pq_op_e            op,
  output logic [1:0]        set_val,
  output logic              access_ok
);
  localparam int HI_W = ADDR_W - PAGE_SHIFT - 1;

  generate
    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : bad_shift_g
      initial $error("PAGE_SHIFT must be 12 or 16");
    end
  endgenerate

  logic [HI_W-1:0] hi;

  always_comb begin
    hi        = addr[ADDR_W-1:PAGE_SHIFT+1];
    idx       = hi[IDX_W-1:0];
    odd_page  = addr[PAGE_SHIFT];
    op        = pq_decode(is_store, addr[11:0]);
    set_val   = pq_set_value(addr[11:0]);
    access_ok = (hi < HI_W'(NUM_DESC)) && (size == 4'd8);
  end
endmodule

// File: rtl/pqm_pq_alu.sv
module pqm_pq_alu
  import pqm_pkg::*;
(
  input  pq_op_e      op,
  input  logic [1:0]  set_val,
  input  logic [1:0]  cur,
  output logic [1:0]  nxt,
  output logic [63:0] result,
  output logic        notify
);
  logic [2:0] trig_r, eoi_r;

  always_comb begin
    trig_r = pq_trigger(cur);
    eoi_r  = pq_eoi(cur);
    nxt    = cur;
    result = '0;
    notify = 1'b0;
    case (op)
      OP_TRIG: begin nxt = trig_r[1:0]; notify = trig_r[2]; end
      OP_EOI:  begin nxt = eoi_r[1:0];  notify = eoi_r[2]; result = {63'd0, eoi_r[2]}; end
      OP_GET:  result = {62'd0, cur};
      OP_SET:  begin nxt = set_val; result = {62'd0, cur}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pqm_desc_store.sv
module pqm_desc_store #(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_odd,
  output logic             rd_valid,
  output logic [1:0]       rd_pq,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_odd,
  input  logic [1:0]       wr_pq
);
  logic [NUM_DESC-1:0]      valid_flat;
  logic [NUM_DESC-1:0][1:0] pq_n_flat;
  logic [NUM_DESC-1:0][1:0] pq_e_flat;

  for (genvar g = 0; g < NUM_DESC; g++) begin : desc_g
    logic       vld_q;
    logic [1:0] n_q, e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        n_q   <= 2'b00;
        e_q   <= 2'b00;
      end else begin
        if (cfg_we && cfg_idx == IDX_W'(g)) vld_q <= cfg_valid;
        if (wr_en && wr_idx == IDX_W'(g)) begin
          if (wr_odd) e_q <= wr_pq;
          else        n_q <= wr_pq;
        end
      end
    end
    assign valid_flat[g] = vld_q;
    assign pq_n_flat[g]  = n_q;
    assign pq_e_flat[g]  = e_q;
  end

  assign rd_valid = valid_flat[rd_idx];
  assign rd_pq    = rd_odd ? pq_e_flat[rd_idx] : pq_n_flat[rd_idx];

  // R11
  pq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pq_n_flat) && $stable(pq_e_flat)));

  // R11
  pq_cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_en) |=> ($stable(pq_n_flat) && $stable(pq_e_flat)));
endmodule

// File: rtl/pq_page_mmio.sv
module pq_page_mmio
  import pqm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 4,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              notify_o,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid
);
  // decoded request
  logic [IDX_W-1:0] dec_idx;
  logic             dec_odd, dec_ok;
  pq_op_e           dec_op;
  logic [1:0]       dec_setv;

  // captured request (first cycle of the RMW)
  logic             busy_q, st_wr, st_odd, st_ok;
  logic [IDX_W-1:0] st_idx;
  pq_op_e           st_op;
  logic [1:0]       st_setv;

  // RMW internals, named for the checks
  logic             accept, rd_valid, desc_ok, wb_en, alu_notify;
  logic [1:0]       rd_pq, alu_pq;
  logic [63:0]      alu_res;

  logic             rsp_valid_q, notify_q;
  logic [63:0]      rsp_data_q;

  pqm_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W)
  ) dec_i (
    .is_store(req_write), .addr(req_addr), .size(req_size),
    .idx(dec_idx), .odd_page(dec_odd), .op(dec_op), .set_val(dec_setv), .access_ok(dec_ok)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      st_wr   <= 1'b0;
      st_odd  <= 1'b0;
      st_ok   <= 1'b0;
      st_idx  <= '0;
      st_op   <= OP_BAD;
      st_setv <= 2'b00;
    end else if (accept) begin
      busy_q  <= 1'b1;
      st_wr   <= req_write;
      st_odd  <= dec_odd;
      st_ok   <= dec_ok;
      st_idx  <= dec_idx;
      st_op   <= dec_op;
      st_setv <= dec_setv;
    end else begin
      busy_q  <= 1'b0;
    end
  end

  pqm_desc_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .rd_idx(st_idx), .rd_odd(st_odd), .rd_valid(rd_valid), .rd_pq(rd_pq),
    .wr_en(wb_en), .wr_idx(st_idx), .wr_odd(st_odd), .wr_pq(alu_pq)
  );

  pqm_pq_alu alu_i (
    .op(st_op), .set_val(st_setv), .cur(rd_pq),
    .nxt(alu_pq), .result(alu_res), .notify(alu_notify)
  );

  assign desc_ok = st_ok && rd_valid && (st_op != OP_BAD);
  assign wb_en   = busy_q && desc_ok && (alu_pq != rd_pq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      notify_q    <= 1'b0;
    end else begin
      rsp_valid_q <= busy_q && !st_wr;
      rsp_data_q  <= desc_ok ? alu_res : ALL_ONES;
      notify_q    <= busy_q && desc_ok && alu_notify;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign notify_o  = notify_q;

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9
  load_rsp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |-> ##2 rsp_valid);

  // R9
  store_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |-> ##2 !rsp_valid);

  // R7
  reject_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !st_wr && !(st_ok && rd_valid)) |=> (rsp_data == ALL_ONES));

  // R10
  notify_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> (st_op == OP_TRIG || st_op == OP_EOI));

  // R10
  notify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |=> !notify_o);
endmodule

// File: tb/pq_page_mmio_tb.sv
`timescale 1ns/1ps
module pq_page_mmio_tb_top;
  localparam int ADDR_W = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int NUM_DESC = 4;
  localparam int IDX_W = 2;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [1:0]  idx;
    logic        odd;
    logic [11:0] off;
    logic [3:0]  sz;
    logic [63:0] exp_d;
    logic        exp_n;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  1'b0, 2'd0, 1'b0, 12'h800, 4'd8, 64'd0, 1'b0}, // R4 fresh state
    '{4'd2,  1'b1, 2'd0, 1'b0, 12'h000, 4'd8, 64'd0, 1'b1}, // R2 00->10 notify
    '{4'd2,  1'b1, 2'd0, 1'b0, 12'h008, 4'd8, 64'd0, 1'b0}, // R2 10->11
    '{4'd4,  1'b0, 2'd0, 1'b0, 12'h900, 4'd8, 64'd3, 1'b0}, // R4 read 11
    '{4'd1,  1'b0, 2'd0, 1'b1, 12'h800, 4'd8, 64'd0, 1'b0}, // R1 odd page untouched
    '{4'd3,  1'b0, 2'd0, 1'b0, 12'h000, 4'd8, 64'd1, 1'b1}, // R3 11->10 ret 1
    '{4'd3,  1'b0, 2'd0, 1'b0, 12'h7F8, 4'd8, 64'd0, 1'b0}, // R3 10->00 ret 0
    '{4'd5,  1'b0, 2'd0, 1'b1, 12'hD00, 4'd8, 64'd0, 1'b0}, // R5 set 01
    '{4'd5,  1'b0, 2'd0, 1'b1, 12'hF00, 4'd8, 64'd1, 1'b0}, // R5 set 11 prev 01
    '{4'd11, 1'b0, 2'd0, 1'b1, 12'h800, 4'd8, 64'd3, 1'b0}, // R11 holds 11
    '{4'd3,  1'b1, 2'd0, 1'b1, 12'h400, 4'd8, 64'd0, 1'b1}, // R3 store EOI 11->10
    '{4'd2,  1'b1, 2'd0, 1'b1, 12'h3F8, 4'd8, 64'd0, 1'b0}, // R2 10->11
    '{4'd5,  1'b0, 2'd1, 1'b0, 12'hC00, 4'd8, 64'd0, 1'b0}, // R5 set 00 prev 00
    '{4'd2,  1'b1, 2'd1, 1'b0, 12'h000, 4'd8, 64'd0, 1'b1}, // R2 00->10 notify
    '{4'd6,  1'b1, 2'd1, 1'b0, 12'h800, 4'd8, 64'd0, 1'b0}, // R6 bad store
    '{4'd6,  1'b0, 2'd1, 1'b0, 12'h800, 4'd8, 64'd2, 1'b0}, // R6 state still 10
    '{4'd7,  1'b0, 2'd3, 1'b0, 12'h800, 4'd8, ONES,  1'b0}, // R7 invalid load
    '{4'd7,  1'b1, 2'd3, 1'b0, 12'h000, 4'd8, 64'd0, 1'b0}, // R7 invalid store
    '{4'd8,  1'b0, 2'd1, 1'b0, 12'h800, 4'd4, ONES,  1'b0}, // R8 short load
    '{4'd8,  1'b1, 2'd1, 1'b0, 12'h000, 4'd4, 64'd0, 1'b0}, // R8 short store
    '{4'd8,  1'b0, 2'd1, 1'b0, 12'h800, 4'd8, 64'd2, 1'b0}, // R8 no change
    '{4'd5,  1'b0, 2'd2, 1'b1, 12'hE00, 4'd8, 64'd0, 1'b0}, // R5 set 10
    '{4'd1,  1'b0, 2'd2, 1'b0, 12'h800, 4'd8, 64'd0, 1'b0}, // R1 even page 00
    '{4'd3,  1'b0, 2'd2, 1'b1, 12'h100, 4'd8, 64'd0, 1'b0}, // R3 10->00 ret 0
    '{4'd3,  1'b1, 2'd1, 1'b0, 12'h400, 4'd8, 64'd0, 1'b0}, // R3 store EOI 10->00
    '{4'd3,  1'b0, 2'd1, 1'b0, 12'hBF8, 4'd8, 64'd0, 1'b0}, // R3 now 00
    '{4'd5,  1'b0, 2'd2, 1'b0, 12'hD00, 4'd8, 64'd0, 1'b0}, // R5 set 01
    '{4'd2,  1'b1, 2'd2, 1'b0, 12'h200, 4'd8, 64'd0, 1'b0}, // R2 01->11
    '{4'd2,  1'b0, 2'd2, 1'b0, 12'h800, 4'd8, 64'd3, 1'b0}, // R2 now 11
    '{4'd5,  1'b0, 2'd2, 1'b0, 12'hD80, 4'd8, 64'd3, 1'b0}, // R5 prev 11, set 01
    '{4'd3,  1'b0, 2'd2, 1'b0, 12'h400, 4'd8, 64'd0, 1'b0}, // R3 01->00 ret 0
    '{4'd3,  1'b0, 2'd2, 1'b0, 12'h800, 4'd8, 64'd0, 1'b0}  // R3 now 00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_size = 4'd8;
  logic cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic req_ready, rsp_valid, notify_o;
  logic [63:0] rsp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pq_page_mmio #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .notify_o(notify_o),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid)
  );

  task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int idx, input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input vec_t v, input int vnum);
    logic rdy, rv, nt;
    logic [63:0] d;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = ADDR_W'({v.idx, v.odd, v.off});
    req_size  = v.sz;
    @(negedge clk);
    req_valid = 1'b0;
    rdy = req_ready;
    @(negedge clk);
    rv = rsp_valid; d = rsp_data; nt = notify_o;
    chk(9, $sformatf("vec %0d ready while busy", vnum), 64'(rdy), 64'd0);
    chk(9, $sformatf("vec %0d rsp_valid", vnum), 64'(rv), 64'(!v.wr));
    if (!v.wr) chk(int'(v.req), $sformatf("vec %0d data", vnum), d, v.exp_d);
    chk(10, $sformatf("vec %0d notify", vnum), 64'(nt), 64'(v.exp_n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(12, "ready after reset", 64'(req_ready), 64'd1);
    chk(12, "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(12, "notify after reset", 64'(notify_o), 64'd0);
    rst_n = 1'b1;
    // R12 descriptors start invalid
    run('{4'd12, 1'b0, 2'd0, 1'b0, 12'h800, 4'd8, ONES, 1'b0}, 100);
    set_cfg(0, 1'b1);
    set_cfg(1, 1'b1);
    set_cfg(2, 1'b1);

    for (int i = 0; i < NV; i++) run(VECS[i], i);

    // R7 invalid descriptor kept its state through the ignored trigger
    set_cfg(3, 1'b1);
    run('{4'd7, 1'b0, 2'd3, 1'b0, 12'h800, 4'd8, 64'd0, 1'b0}, 200);
    // R11 toggling validity preserves the stored state
    set_cfg(0, 1'b0);
    run('{4'd7, 1'b0, 2'd0, 1'b1, 12'h800, 4'd8, ONES, 1'b0}, 201);
    set_cfg(0, 1'b1);
    run('{4'd11, 1'b0, 2'd0, 1'b1, 12'h800, 4'd8, 64'd3, 1'b0}, 202);
    // R1 index at or beyond NUM_DESC is rejected
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 4'd8;
    req_addr = ADDR_W'(32'h0000_8800);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(7, "out-of-range index load", rsp_data, ONES);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule